// File: doc/BRIEF.md
# APB Reload Down-Counter Timer

This block is a 32-bit down-counting timer that software programs through an APB slave port. A control word turns the timer on, arms the interrupt, and picks how an external input pin is used. The pin can serve as a run gate, or its rising edges can replace the bus clock as the tick source. Software loads a reload value, and the counter steps down once per tick. When it steps from one to zero it raises a sticky interrupt flag. It then rests at zero for one tick and loads the reload value again.

The interrupt output is a level that follows the flag. Software clears the flag by writing a one to it. A reload value of zero parks the counter at zero with no further interrupts. A fixed, read-only identification window sits at the top of the 4 KB register space.

Top module: `apb_reload_timer`

## Requirements
- R1: Word offsets are: 0x00 control, 0x04 current count, 0x08 reload, 0x0C interrupt status. In the control word, bit 0 is run, bit 1 is external gate, bit 2 is external clock and bit 3 is interrupt enable. Only these four bits are stored, and bits 31:4 read as zero.
- R2: On each tick, a nonzero count decreases by exactly one. Without a tick (run clear, or no qualifying external condition) the count holds.
- R3: The interrupt flag is set only when a tick moves the count from 1 to 0, and only if interrupt enable is set in that cycle.
- R4: A tick that arrives while the count is zero loads the reload value. With a reload value of zero the count stays at zero, and no further interrupt occurs.
- R5: A write to the reload register puts the written value into both the reload register and the count. A write to the count register changes only the count. Either write takes precedence over a tick in the same cycle.
- R6: Bit 0 of the interrupt status is write-one-to-clear, and a zero written there leaves it unchanged. The interrupt output always equals this bit. A set and a clear in the same cycle leave it set.
- R7: The external input passes through a two-flop synchronizer. In gate mode (control bit 1), no tick occurs while the synchronized input is low.
- R8: In external clock mode (control bit 2), exactly one tick occurs per rising edge of the synchronized input, and there are no ticks at any other time.
- R9: After reset, the control word, count, reload and interrupt status are all zero, the timer is stopped, and the interrupt output is low.
- R10: Byte offsets 0xFD0 through 0xFFC return, in ascending order, the twelve identification bytes 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0. Writes there are ignored, and any other unmapped offset reads zero.
- R11: PREADY is always high and PSLVERR is always low. A write takes effect only in the access phase (PSEL and PENABLE high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never signals an error |
| ext_in | input | 1 | External gate or tick input (asynchronous) |
| irq_o | output | 1 | Level interrupt, equals the status flag |

## Verification
The bench builds the block with its defaults: 32-bit data, a 12-bit address, and two synchronizer stages. The full 32-bit count path and all twelve identification words are therefore exercised. Because the synchronizer is two stages deep, the bench's own model has to reproduce the two-cycle pin latency and the edge detection exactly. Small reload values (0 to 4) bring the 1-to-0 transition, the dwell at zero and the zero-reload park within a few cycles. Toggling the external pin every few cycles makes external-clock ticks sparse enough to check one tick per edge.

// File: rtl/aprt_pkg.sv
package aprt_pkg;

    localparam int CTRL_W        = 4;
    localparam int ID_FIRST_WORD = 'h3F4;
    localparam int ID_WORDS      = 12;

    typedef struct packed {
        logic irq_en;
        logic ext_clk;
        logic ext_gate;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    function automatic logic [7:0] id_byte(input int unsigned k);
        logic [7:0] b;
        case (k)
            0:       b = 8'h04;
            4:       b = 8'h22;
            5:       b = 8'hB8;
            6:       b = 8'h1B;
            8:       b = 8'h0D;
            9:       b = 8'hF0;
            10:      b = 8'h05;
            11:      b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/aprt_tick_gen.sv
module aprt_tick_gen
    import aprt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl_i,
    input  logic  ext_in,
    output logic  tick_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic      level;
    logic      rise;

    assign level = st_q.sync[SYNC_STAGES-1];
    assign rise  = level && !st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ext_in};
        st_d.prev = level;
        tick_o    = ctrl_i.run
                    && (!ctrl_i.ext_gate || level)
                    && (!ctrl_i.ext_clk  || rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_EDGE_SINGLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && ctrl_i.ext_clk) |=> !(tick_o && ctrl_i.ext_clk)); // R8

endmodule

// File: rtl/aprt_counter.sv
module aprt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              irq_en_i,
    input  logic              wr_count_i,
    input  logic              wr_reload_i,
    input  logic              clr_flag_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] reload_o,
    output logic              flag_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] reload;
        logic              flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       terminal;
    logic       wr_any;

    assign wr_any = wr_count_i || wr_reload_i;

    always_comb begin
        st_d     = st_q;
        terminal = 1'b0;
        if (wr_reload_i) begin
            st_d.reload = wdata_i;
            st_d.count  = wdata_i;
        end else if (wr_count_i) begin
            st_d.count = wdata_i;
        end else if (tick_i) begin
            if (st_q.count == '0) begin
                st_d.count = st_q.reload;
            end else begin
                st_d.count = st_q.count - ONE;
                terminal   = (st_q.count == ONE);
            end
        end
        if (terminal && irq_en_i)
            st_d.flag = 1'b1;
        else if (clr_flag_i)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o  = st_q.count;
    assign reload_o = st_q.reload;
    assign flag_o   = st_q.flag;

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_any && st_q.count != '0) |=> st_q.count == $past(st_q.count) - ONE); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_any) |=> $stable(st_q.count)); // R2
    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> ($past(st_q.count) == ONE && st_q.count == '0)); // R3
    AST_DWELL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_any && st_q.count == '0) |=> st_q.count == $past(st_q.reload)); // R4
    AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload_i |=> st_q.count == st_q.reload); // R5

endmodule

// File: rtl/aprt_regs.sv
module aprt_regs
    import aprt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] count_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic              flag_i,
    output ctrl_t             ctrl_o,
    output logic              wr_count_o,
    output logic              wr_reload_o,
    output logic              clr_flag_o,
    output logic [DATA_W-1:0] prdata
);

    localparam int WIDX_W = ADDR_W - 2;

    typedef struct packed {
        ctrl_t ctrl;
    } reg_state_t;

    reg_state_t        st_d, st_q;
    logic [WIDX_W-1:0] widx;
    logic              wr_acc;
    logic              low_word;
    reg_sel_e          sel;
    int unsigned       id_k;
    logic              unused_addr_lsb;

    assign widx            = paddr[ADDR_W-1:2];
    assign unused_addr_lsb = ^paddr[1:0];
    assign wr_acc          = psel && penable && pwrite;
    assign low_word        = (widx >> 2) == '0;
    assign sel             = reg_sel_e'(widx[1:0]);
    assign id_k            = int'(widx) - ID_FIRST_WORD;

    always_comb begin
        st_d        = st_q;
        wr_count_o  = 1'b0;
        wr_reload_o = 1'b0;
        clr_flag_o  = 1'b0;
        if (wr_acc && low_word) begin
            case (sel)
                SEL_CTRL:   st_d.ctrl   = ctrl_t'(pwdata[CTRL_W-1:0]);
                SEL_COUNT:  wr_count_o  = 1'b1;
                SEL_RELOAD: wr_reload_o = 1'b1;
                SEL_STATUS: clr_flag_o  = pwdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (low_word) begin
            case (sel)
                SEL_CTRL:   prdata = {{(DATA_W-CTRL_W){1'b0}}, st_q.ctrl};
                SEL_COUNT:  prdata = count_i;
                SEL_RELOAD: prdata = reload_i;
                SEL_STATUS: prdata = {{(DATA_W-1){1'b0}}, flag_i};
                default:    prdata = '0;
            endcase
        end else if (int'(widx) >= ID_FIRST_WORD && int'(widx) < ID_FIRST_WORD + ID_WORDS) begin
            prdata = {{(DATA_W-8){1'b0}}, id_byte(id_k)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;

    AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ctrl) |-> $past(wr_acc && widx == '0)); // R1
    AST_SETUP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> $stable(st_q.ctrl)); // R11

endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer
    import aprt_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ext_in,
    output logic              irq_o
);

    ctrl_t             ctrl;
    logic              tick;
    logic              wr_count;
    logic              wr_reload;
    logic              clr_flag;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] reload;
    logic              flag;

    aprt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(pclk), .rst_n(presetn),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata),
        .count_i(count), .reload_i(reload), .flag_i(flag),
        .ctrl_o(ctrl), .wr_count_o(wr_count), .wr_reload_o(wr_reload),
        .clr_flag_o(clr_flag), .prdata(prdata)
    );

    aprt_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(pclk), .rst_n(presetn), .ctrl_i(ctrl), .ext_in(ext_in), .tick_o(tick)
    );

    aprt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .tick_i(tick), .irq_en_i(ctrl.irq_en),
        .wr_count_i(wr_count), .wr_reload_i(wr_reload), .clr_flag_i(clr_flag),
        .wdata_i(pwdata), .count_o(count), .reload_o(reload), .flag_o(flag)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_o   = flag;

    AST_IRQ_W1C: assert property (@(posedge pclk) disable iff (!presetn)
        (clr_flag && !tick) |=> !irq_o); // R6

endmodule

// File: tb/apb_reload_timer_tb_top.sv
module apb_reload_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        ext_in = 1'b0;
    logic        irq_o;

    int checks = 0;
    int failures = 0;

    apb_reload_timer dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    // behavioural reference
    logic [3:0]  m_ctrl = '0;
    logic [31:0] m_count = '0, m_reload = '0;
    logic        m_flag = 1'b0;
    logic        m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;
    logic        m_tick, m_wr, m_cntwr, m_term;
    int          m_idx;
    int          id_tab [12] = '{'h04, 'h00, 'h00, 'h00, 'h22, 'hB8, 'h1B, 'h00,
                                 'h0D, 'hF0, 'h05, 'hB1};

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int w;
        w = int'(a) / 4;
        if (w == 0) return {28'd0, m_ctrl};
        if (w == 1) return m_count;
        if (w == 2) return m_reload;
        if (w == 3) return {31'd0, m_flag};
        if (w >= 'h3F4 && w <= 'h3FF) return 32'(id_tab[w - 'h3F4]);
        return 32'd0;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        int w;
        w = int'(a) / 4;
        if (w == 0) return "R1";
        if (w == 1) return "R2";
        if (w == 2) return "R5";
        if (w == 3) return "R6";
        return "R10";
    endfunction

    always @(posedge pclk) begin
        if (!presetn) begin
            m_ctrl = '0; m_count = '0; m_reload = '0; m_flag = 1'b0;
            m_s1 = 1'b0; m_s2 = 1'b0; m_prev = 1'b0;
        end else begin
            m_wr    = psel && penable && pwrite;
            m_idx   = int'(paddr) / 4;
            m_tick  = m_ctrl[0] && (!m_ctrl[1] || m_s2) && (!m_ctrl[2] || (m_s2 && !m_prev));
            m_cntwr = m_wr && (m_idx == 1 || m_idx == 2);
            m_term  = 1'b0;
            if (m_wr && m_idx == 2) begin
                m_reload = pwdata; m_count = pwdata;
            end else if (m_wr && m_idx == 1) begin
                m_count = pwdata;
            end else if (m_tick) begin
                if (m_count == 0) m_count = m_reload;
                else begin
                    m_term  = (m_count == 1);
                    m_count = m_count - 1;
                end
            end
            if (m_term && m_ctrl[3]) m_flag = 1'b1;
            else if (m_wr && m_idx == 3 && pwdata[0]) m_flag = 1'b0;
            if (m_wr && m_idx == 0) m_ctrl = pwdata[3:0];
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_in;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    always @(negedge pclk) begin
        #1;
        if (presetn) begin
            check(irq_o == m_flag, "R6", "irq_o vs model", 32'(irq_o), 32'(m_flag));
            check(pready && !pslverr, "R11", "pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
            if (psel && penable && !pwrite)
                check(prdata == model_read(paddr), tag_of(paddr), "read data",
                      prdata, model_read(paddr));
        end
    end

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1;
        #2 d = prdata;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic toggle_ext(input int edges, input int half);
        for (int i = 0; i < edges; i++) begin
            @(negedge pclk); ext_in = ~ext_in;
            idle(half);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge pclk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] r, r2;
        idle(3);
        presetn = 1'b1;
        idle(2);

        // R9 reset state
        check(irq_o == 1'b0, "R9", "irq after reset", 32'(irq_o), 0);
        for (int a = 0; a < 16; a += 4) begin
            apb_rd(12'(a), r);
            check(r == 0, "R9", "register after reset", r, 0);
        end

        // R1 only low four control bits kept
        apb_wr(12'h000, 32'hFFFF_FFF0);
        apb_rd(12'h000, r);
        check(r == 32'h0, "R1", "ctrl upper bits", r, 32'h0);
        apb_wr(12'h000, 32'hFFFF_FFF8);
        apb_rd(12'h000, r);
        check(r == 32'h8, "R1", "ctrl irq_en only", r, 32'h8);

        // R5 reload write loads count; count write leaves reload
        apb_wr(12'h008, 32'd3);
        apb_rd(12'h004, r);
        check(r == 32'd3, "R5", "count after reload write", r, 32'd3);
        apb_wr(12'h004, 32'h55);
        apb_rd(12'h008, r);
        check(r == 32'd3, "R5", "reload after count write", r, 32'd3);
        apb_rd(12'h004, r);
        check(r == 32'h55, "R5", "count write", r, 32'h55);

        // R11 setup phase alone does nothing
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h000; pwdata = 32'hF;
        @(negedge pclk); psel = 0; pwrite = 0;
        apb_rd(12'h000, r);
        check(r == 32'h8, "R11", "ctrl after setup-only", r, 32'h8);

        // R2/R3/R4 run with interrupt enabled
        apb_wr(12'h008, 32'd3);
        apb_wr(12'h000, 32'h9);
        idle(20);
        check(irq_o == 1'b1, "R3", "irq after 1->0", 32'(irq_o), 1);
        apb_wr(12'h000, 32'h0);
        apb_rd(12'h004, r);
        idle(5);
        apb_rd(12'h004, r2);
        check(r == r2, "R2", "count holds when stopped", r2, r);

        // R6 W1C
        apb_wr(12'h00C, 32'h0);
        apb_rd(12'h00C, r);
        check(r == 32'h1, "R6", "status after writing 0", r, 32'h1);
        apb_wr(12'h00C, 32'h1);
        apb_rd(12'h00C, r);
        check(r == 32'h0, "R6", "status after writing 1", r, 32'h0);

        // R2 counting down
        apb_wr(12'h008, 32'd100);
        apb_wr(12'h000, 32'h1);
        apb_rd(12'h004, r);
        idle(4);
        apb_rd(12'h004, r2);
        check(r2 < r, "R2", "count decreasing", r2, r);

        // R3 interrupt disabled: no flag
        apb_wr(12'h008, 32'd2);
        idle(20);
        check(irq_o == 1'b0, "R3", "no irq when disabled", 32'(irq_o), 0);

        // R4 zero reload parks at zero
        apb_wr(12'h000, 32'h9);
        apb_wr(12'h008, 32'd0);
        apb_wr(12'h00C, 32'h1);
        idle(30);
        check(irq_o == 1'b0, "R4", "no irq with zero reload", 32'(irq_o), 0);
        apb_rd(12'h004, r);
        check(r == 0, "R4", "count parked", r, 0);

        // R7 gate mode
        apb_wr(12'h000, 32'h0);
        apb_wr(12'h008, 32'd10);
        ext_in = 1'b0;
        idle(4);
        apb_wr(12'h000, 32'hB);
        idle(10);
        apb_rd(12'h004, r);
        check(r == 32'd10, "R7", "gated count holds", r, 32'd10);
        ext_in = 1'b1;
        idle(25);
        ext_in = 1'b0;
        idle(6);

        // R8 external clock mode
        apb_wr(12'h000, 32'h0);
        apb_wr(12'h00C, 32'h1);
        apb_wr(12'h008, 32'd4);
        apb_wr(12'h000, 32'hD);
        toggle_ext(24, 3);
        apb_rd(12'h004, r);
        idle(10);
        apb_rd(12'h004, r2);
        check(r == r2, "R8", "no tick without edges", r2, r);
        toggle_ext(8, 1);

        // R10 identification window
        apb_wr(12'h000, 32'h0);
        for (int k = 0; k < 12; k++) begin
            apb_rd(12'hFD0 + 12'(4 * k), r);
            check(r == 32'(id_tab[k]), "R10", "id byte", r, 32'(id_tab[k]));
        end
        apb_wr(12'hFD0, 32'h77);
        apb_rd(12'hFD0, r);
        check(r == 32'h04, "R10", "id write ignored", r, 32'h04);
        apb_rd(12'h010, r);
        check(r == 0, "R10", "unmapped low", r, 0);
        apb_rd(12'h7FC, r);
        check(r == 0, "R10", "unmapped mid", r, 0);

        idle(4);
        finish_run();
    end

endmodule